// File: doc/BRIEF.md
# Pulse-swallow dual-modulus frequency divider

This block is the feedback divider of a frequency synthesizer, built entirely in digital logic. It runs on the RF input clock. A prescaler counts that clock in groups of P or P+1 cycles. A swallow counter and a main counter count the prescaler's groups. The swallow counter holds the prescaler at P+1 for the first A groups of each output period. After that, the main counter runs out its remaining groups at P. Each output period is therefore B·P + A RF cycles long. The base modulus P is chosen from two values: 8 (an 8/9 prescaler) or 32 (a 32/33 prescaler).

A separate reference divider runs in its own clock domain. It divides the reference clock by R to set the comparison rate. Both paths emit a single-cycle pulse when their count terminates.

Each path takes new settings through a load strobe. A new setting is checked and held aside, then adopted at that path's next wrap, so the period in progress is never cut short. Each path also has a synchronous counter-hold input. While the hold is high, the path's counters stay at their starting values and any waiting setting is adopted at once.

Top module: `pulse_swallow_divider`

## Requirements
- R1: After reset, both pulse outputs and both error flags are low. The feedback path starts with A=0, B=3, P=8, so pulses are 24 RF cycles apart. The reference path starts with R=4, so pulses are 4 reference cycles apart.
- R2: The feedback pulse period is B·P + A RF cycles. A is the 5-bit `cfg_a`, B is the 13-bit `cfg_b`, and `cfg_psel`=0 selects P=8 while `cfg_psel`=1 selects P=32.
- R3: In every output period, the prescaler divides by P+1 for the first A prescaler cycles and by P for the rest. It never returns to P+1 before the next wrap.
- R4: A feedback load is accepted only when B ≥ A and B ≥ 3. A rejected load drives `cfg_err` high for exactly the cycle after the strobe and leaves the setting in force unchanged. An accepted load leaves `cfg_err` low.
- R5: An accepted A/B/P setting takes effect at the next feedback wrap. The period in progress finishes with the old ratio. If several loads arrive before a wrap, the last accepted one wins.
- R6: The reference pulse period is R reference cycles, with R the 14-bit `r_val`. R=0 is rejected: `r_err` goes high for the cycle after the strobe and the old R stays in force.
- R7: An accepted R takes effect at the next reference wrap. The period in progress completes with the old R.
- R8: While a hold input is high, its path emits no pulses. After the hold is released, the first pulse arrives exactly one full period (N or R cycles) after the last clock edge that saw the hold high. A setting that was waiting when the hold was applied is the one in force for that period.
- R9: Each output pulse lasts one cycle of its own clock. The exception is R=1, where the reference output stays high.
- R10: The feedback divider reaches the large ratio N=175000 (P=32, B=5468, A=24) with the exact period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_clk | input | 1 | RF input clock, which clocks the whole feedback path |
| rf_rst_n | input | 1 | Synchronous active-low reset for the feedback path |
| rf_hold | input | 1 | Synchronous counter hold for the feedback path |
| cfg_load | input | 1 | Strobe that presents a new A/B/P setting |
| cfg_a | input | 5 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| cfg_psel | input | 1 | Prescaler base: 0 selects 8, 1 selects 32 |
| cfg_err | output | 1 | One-cycle flag raised when an A/B load is rejected |
| fb_pulse | output | 1 | Divided feedback pulse, one RF cycle wide |
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Synchronous active-low reset for the reference path |
| ref_hold | input | 1 | Synchronous counter hold for the reference path |
| r_load | input | 1 | Strobe that presents a new R |
| r_val | input | 14 | Reference division ratio R |
| r_err | output | 1 | One-cycle flag raised when an R load is rejected |
| ref_pulse | output | 1 | Divided reference pulse, one reference cycle wide |

## Verification
The bench builds the block with its default parameters: 5-bit A, 13-bit B, 14-bit R, prescaler choices 8 and 32, and a reset setting of A=0, B=3, R=4. The short reset ratio of 24 lets the reset behaviour be measured within a few dozen cycles. The full counter widths bring the 175000 ratio and the R=50 comparison divider within reach, and both prescaler bases are exercised with random legal A/B sets. Small B values keep the boundary rules B ≥ A and B ≥ 3 easy to hit from both sides.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Legality of a swallow/main pair: the main count must cover the swallow
  // count and be at least three prescaler cycles long.
  function automatic logic ab_legal(input int unsigned a, input int unsigned b);
    return (b >= a) && (b >= 32'd3);
  endfunction

  // A reference ratio of zero has no meaning.
  function automatic logic r_legal(input int unsigned r);
    return r != 32'd0;
  endfunction

  // Cycles in one prescaler group: the base, plus one while swallowing.
  function automatic int unsigned group_len(input int unsigned p_base, input logic swallow);
    return swallow ? p_base + 32'd1 : p_base;
  endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int PS_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [PS_W-1:0] modulus,
  output logic            tick
);
  logic [PS_W-1:0] cnt;

  // The last cycle of the current group.
  assign tick = (cnt == modulus - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || hold)  cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psd_swallow_main.sv
module psd_swallow_main
  import psd_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int DEF_A = 0,
  parameter int DEF_B = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           cfg_load,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  input  logic           cfg_psel,
  input  logic           ps_tick,
  output logic           mod_hi,
  output logic           p_act,
  output logic [A_W-1:0] a_act,
  output logic [B_W-1:0] b_act,
  output logic           fb_wrap,
  output logic           fb_pulse,
  output logic           cfg_err
);
  logic [A_W-1:0] a_rem, a_pnd, a_nxt;
  logic [B_W-1:0] b_rem, b_pnd, b_nxt;
  logic           p_pnd, p_nxt, pnd_vld, load_ok, restart;

  assign load_ok = ab_legal(32'(cfg_a), 32'(cfg_b));
  assign fb_wrap = ps_tick && (b_rem == B_W'(1));
  assign mod_hi  = (a_rem != '0);
  assign restart = hold || fb_wrap;

  // A waiting setting wins at a restart.
  always_comb begin
    a_nxt = pnd_vld ? a_pnd : a_act;
    b_nxt = pnd_vld ? b_pnd : b_act;
    p_nxt = pnd_vld ? p_pnd : p_act;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_act    <= A_W'(DEF_A);
      b_act    <= B_W'(DEF_B);
      p_act    <= 1'b0;
      a_rem    <= A_W'(DEF_A);
      b_rem    <= B_W'(DEF_B);
      a_pnd    <= '0;
      b_pnd    <= '0;
      p_pnd    <= 1'b0;
      pnd_vld  <= 1'b0;
      fb_pulse <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err  <= cfg_load && !load_ok;
      fb_pulse <= fb_wrap && !hold;
      if (restart) begin
        a_act <= a_nxt;
        b_act <= b_nxt;
        p_act <= p_nxt;
        a_rem <= a_nxt;
        b_rem <= b_nxt;
      end else if (ps_tick) begin
        b_rem <= b_rem - 1'b1;
        if (mod_hi) a_rem <= a_rem - 1'b1;
      end
      if (cfg_load && load_ok) begin
        a_pnd   <= cfg_a;
        b_pnd   <= cfg_b;
        p_pnd   <= cfg_psel;
        pnd_vld <= 1'b1;
      end else if (restart) begin
        pnd_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div
  import psd_pkg::*;
#(
  parameter int R_W   = 14,
  parameter int DEF_R = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           r_load,
  input  logic [R_W-1:0] r_val,
  output logic [R_W-1:0] r_act,
  output logic           r_wrap,
  output logic           ref_pulse,
  output logic           r_err
);
  logic [R_W-1:0] r_cnt, r_pnd;
  logic           pnd_vld, load_ok;

  assign load_ok = r_legal(32'(r_val));
  assign r_wrap  = (r_cnt == r_act - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_cnt     <= '0;
      r_act     <= R_W'(DEF_R);
      r_pnd     <= '0;
      pnd_vld   <= 1'b0;
      ref_pulse <= 1'b0;
      r_err     <= 1'b0;
    end else begin
      r_err     <= r_load && !load_ok;
      ref_pulse <= r_wrap && !hold;
      if (hold || r_wrap) begin
        r_cnt <= '0;
        if (pnd_vld) r_act <= r_pnd;
      end else begin
        r_cnt <= r_cnt + 1'b1;
      end
      if (r_load && load_ok) begin
        r_pnd   <= r_val;
        pnd_vld <= 1'b1;
      end else if (hold || r_wrap) begin
        pnd_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int A_W     = 5,
  parameter int B_W     = 13,
  parameter int R_W     = 14,
  parameter int P_SMALL = 8,
  parameter int P_LARGE = 32,
  parameter int DEF_A   = 0,
  parameter int DEF_B   = 3,
  parameter int DEF_R   = 4
) (
  input  logic           rf_clk,
  input  logic           rf_rst_n,
  input  logic           rf_hold,
  input  logic           cfg_load,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  input  logic           cfg_psel,
  output logic           cfg_err,
  output logic           fb_pulse,
  input  logic           ref_clk,
  input  logic           ref_rst_n,
  input  logic           ref_hold,
  input  logic           r_load,
  input  logic [R_W-1:0] r_val,
  output logic           r_err,
  output logic           ref_pulse
);
  localparam int PS_W = $clog2(P_LARGE + 2);

  // Named internal events, brought out for the checker.
  logic            ps_tick, mod_hi, p_act, fb_wrap, r_wrap;
  logic [A_W-1:0]  a_act;
  logic [B_W-1:0]  b_act;
  logic [R_W-1:0]  r_act;
  logic [PS_W-1:0] ps_modulus;

  assign ps_modulus = PS_W'(group_len(p_act ? P_LARGE : P_SMALL, mod_hi));

  psd_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(rf_clk), .rst_n(rf_rst_n), .hold(rf_hold),
    .modulus(ps_modulus), .tick(ps_tick)
  );

  psd_swallow_main #(.A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_ab (
    .clk(rf_clk), .rst_n(rf_rst_n), .hold(rf_hold),
    .cfg_load(cfg_load), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_psel(cfg_psel),
    .ps_tick(ps_tick), .mod_hi(mod_hi), .p_act(p_act),
    .a_act(a_act), .b_act(b_act), .fb_wrap(fb_wrap),
    .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  psd_ref_div #(.R_W(R_W), .DEF_R(DEF_R)) u_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .hold(ref_hold),
    .r_load(r_load), .r_val(r_val), .r_act(r_act), .r_wrap(r_wrap),
    .ref_pulse(ref_pulse), .r_err(r_err)
  );
endmodule

// File: rtl/psd_checker.sv
module psd_checker
  import psd_pkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 13,
  parameter int R_W = 14
) (
  input logic           rf_clk,
  input logic           rf_rst_n,
  input logic           rf_hold,
  input logic           cfg_load,
  input logic [A_W-1:0] cfg_a,
  input logic [B_W-1:0] cfg_b,
  input logic           cfg_err,
  input logic           fb_pulse,
  input logic           fb_wrap,
  input logic           ps_tick,
  input logic           mod_hi,
  input logic           p_act,
  input logic [A_W-1:0] a_act,
  input logic [B_W-1:0] b_act,
  input logic           ref_clk,
  input logic           ref_rst_n,
  input logic           ref_hold,
  input logic           r_load,
  input logic [R_W-1:0] r_val,
  input logic [R_W-1:0] r_act,
  input logic           r_wrap,
  input logic           r_err,
  input logic           ref_pulse
);
  a_r2_wrap_gives_pulse: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    fb_wrap && !rf_hold |=> fb_pulse);

  a_r3_no_return_to_high: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    ps_tick && !mod_hi && !fb_wrap && !rf_hold |=> !mod_hi);

  a_r3_swallow_follows_a: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    fb_wrap && !rf_hold |=> (mod_hi == (a_act != '0)));

  a_r4_reject_flagged: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    cfg_load && !ab_legal(32'(cfg_a), 32'(cfg_b)) |=> cfg_err);

  a_r4_accept_quiet: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    cfg_load && ab_legal(32'(cfg_a), 32'(cfg_b)) |=> !cfg_err);

  a_r4_active_legal: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    ab_legal(32'(a_act), 32'(b_act)));

  a_r5_setting_held_midperiod: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    !fb_wrap && !rf_hold |=> $stable(a_act) && $stable(b_act) && $stable(p_act));

  a_r6_ratio_nonzero: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    r_act != '0);

  a_r6_zero_flagged: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    r_load && (r_val == '0) |=> r_err);

  a_r7_ratio_held_midperiod: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !r_wrap && !ref_hold |=> $stable(r_act));

  a_r8_fb_quiet_in_hold: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    rf_hold |=> !fb_pulse);

  a_r8_ref_quiet_in_hold: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ref_hold |=> !ref_pulse);

  a_r9_fb_single: assert property (@(posedge rf_clk) disable iff (!rf_rst_n)
    fb_pulse |=> !fb_pulse);

  a_r9_ref_single: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ref_pulse && (r_act != R_W'(1)) && !r_load |=> !ref_pulse);
endmodule

bind pulse_swallow_divider psd_checker #(.A_W(A_W), .B_W(B_W), .R_W(R_W)) u_chk (
  .rf_clk(rf_clk), .rf_rst_n(rf_rst_n), .rf_hold(rf_hold),
  .cfg_load(cfg_load), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_err(cfg_err),
  .fb_pulse(fb_pulse), .fb_wrap(fb_wrap), .ps_tick(ps_tick), .mod_hi(mod_hi),
  .p_act(p_act), .a_act(a_act), .b_act(b_act),
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .ref_hold(ref_hold),
  .r_load(r_load), .r_val(r_val), .r_act(r_act), .r_wrap(r_wrap),
  .r_err(r_err), .ref_pulse(ref_pulse)
);

// File: tb/sim_pulse_swallow_divider.sv
module sim_pulse_swallow_divider;
  localparam int RF_PERIOD  = 10;
  localparam int REF_PERIOD = 14;

  logic        rf_clk = 1'b0, ref_clk = 1'b0;
  logic        rf_rst_n = 1'b0, ref_rst_n = 1'b0;
  logic        rf_hold = 1'b0, ref_hold = 1'b0;
  logic        cfg_load = 1'b0, cfg_psel = 1'b0, r_load = 1'b0;
  logic [4:0]  cfg_a = '0;
  logic [12:0] cfg_b = '0;
  logic [13:0] r_val = '0;
  logic        cfg_err, fb_pulse, r_err, ref_pulse;
  int          n_checks = 0, n_errors = 0;

  always #(RF_PERIOD/2)  rf_clk  = ~rf_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  pulse_swallow_divider u0 (
    .rf_clk(rf_clk), .rf_rst_n(rf_rst_n), .rf_hold(rf_hold),
    .cfg_load(cfg_load), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_psel(cfg_psel),
    .cfg_err(cfg_err), .fb_pulse(fb_pulse),
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .ref_hold(ref_hold),
    .r_load(r_load), .r_val(r_val), .r_err(r_err), .ref_pulse(ref_pulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected ratio written as swallowed groups plus plain groups.
  function automatic int ratio(input int a, input int b, input int psel);
    int p;
    p = psel ? 32 : 8;
    return a * (p + 1) + (b - a) * p;
  endfunction

  task automatic wait_fb(input int limit, output int n);
    n = 0;
    do begin @(negedge rf_clk); n++; end while (!fb_pulse && n < limit);
  endtask

  task automatic wait_ref(input int limit, output int n);
    n = 0;
    do begin @(negedge ref_clk); n++; end while (!ref_pulse && n < limit);
  endtask

  task automatic rf_load(input int a, input int b, input int psel, output bit err);
    @(negedge rf_clk);
    cfg_a = 5'(a); cfg_b = 13'(b); cfg_psel = psel[0]; cfg_load = 1'b1;
    @(negedge rf_clk);
    cfg_load = 1'b0;
    err = cfg_err;
  endtask

  task automatic rf_restart();
    rf_hold = 1'b1;
    @(negedge rf_clk);
    rf_hold = 1'b0;
  endtask

  task automatic ref_set(input int r, output bit err);
    @(negedge ref_clk);
    r_val = 14'(r); r_load = 1'b1;
    @(negedge ref_clk);
    r_load = 1'b0; err = r_err; ref_hold = 1'b1;
    @(negedge ref_clk);
    ref_hold = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    rf_rst_n = 1'b0; ref_rst_n = 1'b0;
    repeat (4) @(negedge rf_clk);
    rf_rst_n = 1'b1; ref_rst_n = 1'b1;
    @(negedge rf_clk);
    check(!fb_pulse && !cfg_err, "R1 rf outputs low after reset", {fb_pulse, cfg_err}, 0);
    @(negedge ref_clk);
    check(!ref_pulse && !r_err, "R1 ref outputs low after reset", {ref_pulse, r_err}, 0);
    wait_fb(100, n);
    wait_fb(100, n);
    check(n == ratio(0, 3, 0), "R1 default feedback period", n, ratio(0, 3, 0));
    @(negedge rf_clk);
    check(!fb_pulse, "R9 feedback pulse one cycle", fb_pulse, 0);
    wait_ref(100, n);
    wait_ref(100, n);
    check(n == 4, "R1 default reference period", n, 4);
  endtask

  task automatic t_random();
    for (int k = 0; k < 6; k++) begin
      int a, b, p, n1, n2;
      bit err;
      p = k % 2;
      b = 3 + int'($urandom % 18);
      a = int'($urandom % (b + 1));
      rf_load(a, b, p, err);
      check(!err, "R4 legal load not flagged", err, 0);
      rf_restart();
      wait_fb(2000, n1);
      check(n1 == ratio(a, b, p), "R8 first period after hold", n1, ratio(a, b, p));
      wait_fb(2000, n2);
      check(n2 == ratio(a, b, p), "R2 R3 period B*P+A", n2, ratio(a, b, p));
    end
  endtask

  task automatic t_illegal();
    int n;
    bit err;
    rf_load(5, 10, 0, err);
    rf_restart();
    wait_fb(1000, n);
    check(n == 85, "R2 period 85", n, 85);
    rf_load(12, 10, 1, err);
    check(err, "R4 A above B flagged", err, 1);
    @(negedge rf_clk);
    check(!cfg_err, "R4 flag lasts one cycle", cfg_err, 0);
    rf_load(0, 2, 0, err);
    check(err, "R4 B below 3 flagged", err, 1);
    rf_restart();
    wait_fb(1000, n);
    check(n == 85, "R4 rejected load leaves setting", n, 85);
    rf_load(3, 3, 0, err);
    check(!err, "R4 B equal A equal 3 accepted", err, 0);
    rf_restart();
    wait_fb(1000, n);
    check(n == ratio(3, 3, 0), "R3 all groups swallowed", n, ratio(3, 3, 0));
  endtask

  task automatic t_deferred();
    int n, cnt;
    bit err;
    rf_load(5, 10, 0, err);
    rf_restart();
    wait_fb(1000, n);
    cnt = 0;
    repeat (5) begin @(negedge rf_clk); cnt++; end
    cfg_a = 5'd3; cfg_b = 13'd4; cfg_psel = 1'b0; cfg_load = 1'b1;
    @(negedge rf_clk); cnt++;
    cfg_a = 5'd3; cfg_b = 13'd4; cfg_psel = 1'b1;
    @(negedge rf_clk); cnt++;
    cfg_load = 1'b0;
    wait_fb(1000, n);
    cnt += n;
    check(cnt == 85, "R5 period in progress keeps old ratio", cnt, 85);
    wait_fb(1000, n);
    check(n == ratio(3, 4, 1), "R5 last load adopted at wrap", n, ratio(3, 4, 1));
  endtask

  task automatic t_hold();
    int n, seen;
    bit err;
    rf_load(0, 3, 0, err);
    rf_restart();
    @(negedge rf_clk);
    rf_hold = 1'b1;
    seen = 0;
    repeat (40) begin @(negedge rf_clk); if (fb_pulse) seen++; end
    check(seen == 0, "R8 no feedback pulse while held", seen, 0);
    rf_hold = 1'b0;
    wait_fb(1000, n);
    check(n == 24, "R8 period after hold release", n, 24);
  endtask

  task automatic t_reference();
    int n, cnt;
    bit err;
    ref_set(50, err);
    check(!err, "R6 R=50 accepted", err, 0);
    wait_ref(500, n);
    check(n == 50, "R8 first reference period after hold", n, 50);
    wait_ref(500, n);
    check(n == 50, "R6 reference period 50", n, 50);
    ref_set(0, err);
    check(err, "R6 R=0 flagged", err, 1);
    wait_ref(500, n);
    check(n == 50, "R6 R=0 keeps old ratio", n, 50);
    @(negedge ref_clk);
    check(!ref_pulse, "R9 reference pulse one cycle", ref_pulse, 0);
    wait_ref(500, n);
    cnt = 0;
    repeat (3) begin @(negedge ref_clk); cnt++; end
    r_val = 14'd7; r_load = 1'b1;
    @(negedge ref_clk); cnt++;
    r_load = 1'b0;
    wait_ref(500, n);
    cnt += n;
    check(cnt == 50, "R7 reference period in progress completes", cnt, 50);
    wait_ref(500, n);
    check(n == 7, "R7 new R adopted at wrap", n, 7);
    ref_hold = 1'b1;
    cnt = 0;
    repeat (20) begin @(negedge ref_clk); if (ref_pulse) cnt++; end
    check(cnt == 0, "R8 no reference pulse while held", cnt, 0);
    ref_hold = 1'b0;
    ref_set(1, err);
    wait_ref(10, n);
    wait_ref(10, n);
    check(n == 1, "R9 R=1 pulses every cycle", n, 1);
  endtask

  task automatic t_large();
    int n;
    bit err;
    rf_load(24, 5468, 1, err);
    check(!err, "R10 large setting accepted", err, 0);
    rf_restart();
    wait_fb(180000, n);
    check(n == 175000, "R10 period 175000", n, ratio(24, 5468, 1));
  endtask

  initial begin
    #(RF_PERIOD * 199000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_illegal();
    t_random();
    t_deferred();
    t_hold();
    t_reference();
    t_large();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule